// File: doc/BRIEF.md
# Round-Robin Transmit Queue Scheduler

This block chooses which transmit queue a port serves next. Software turns individual queues on and off through a small configuration port. A doorbell stream reports that a queue has new work. A FIFO holds the indices of queues that have work, and its order is the round-robin service order. For each transmit it issues a command that carries the queue index and a tracking tag. The tag is the index of a free slot in an operation table of outstanding commands. A status stream returns the tag and a length, and that length decides whether the queue is served again.

Per-queue state is kept in a small RAM with a two-cycle read: an enable bit, an active bit (queued or outstanding), and a pending bit (a doorbell arrived while active). A single control FSM handles one event at a time and moves through four states:

- IDLE accepts an event.
- LOOK waits out the RAM read.
- APPLY writes the updated state and may push the FIFO.
- CMD offers a command until it is accepted.

The transitions are:

- IDLE→LOOK when an event is taken.
- LOOK→APPLY always.
- APPLY→CMD when a popped queue is enabled, otherwise APPLY→IDLE.
- CMD→IDLE on the command handshake.

Top module: `txq_rr_sched`

## Requirements
- R1: After reset every queue is disabled and inactive, cmd_valid is low, and all three input ready outputs are high while their inputs are idle.
- R2: A configuration write with cfg_enable=1 enables queue cfg_queue, and one with cfg_enable=0 disables it.
- R3: A doorbell for a disabled queue is ignored and leads to no command.
- R4: A doorbell for an enabled, inactive queue appends it to the FIFO tail. Commands are issued in FIFO order.
- R5: A doorbell for a queue that is already active only sets its pending flag. A queue is never in the FIFO twice, and a success status clears the pending flag.
- R6: cmd_tag is the lowest-numbered free operation slot (0 to NSLOT-1). No command is offered while all slots are busy.
- R7: A status with a nonzero st_len is a success. It frees slot st_tag and re-appends the queue at the FIFO tail.
- R8: A status with st_len=0 is a failure (queue empty or disabled). It frees the slot and drops the queue, unless the queue is pending, in which case the queue is re-appended once and the pending flag is cleared.
- R9: A disabled queue popped from the FIFO is discarded without a command and becomes inactive, so a later doorbell after it is re-enabled schedules it again.
- R10: While cmd_valid is high and cmd_ready is low, cmd_valid, cmd_queue and cmd_tag hold steady.
- R11: In IDLE at most one input is accepted, with priority configuration, then status, then doorbell. A FIFO pop is done only when none of them is offered.
- R12: The FIFO (depth NQ) is never pushed while full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration write request |
| cfg_ready | output | 1 | Configuration write accepted |
| cfg_queue | input | QW | Queue being configured |
| cfg_enable | input | 1 | 1 enables, 0 disables |
| db_valid | input | 1 | Doorbell valid |
| db_ready | output | 1 | Doorbell accepted |
| db_queue | input | QW | Queue with new work |
| cmd_valid | output | 1 | Transmit command valid |
| cmd_ready | input | 1 | Transmit command accepted |
| cmd_queue | output | QW | Queue to transmit from |
| cmd_tag | output | TW | Operation slot tag |
| st_valid | input | 1 | Status valid |
| st_ready | output | 1 | Status accepted |
| st_tag | input | TW | Tag of finished command |
| st_len | input | LEN_W | Bytes sent; 0 means failure |

## Verification
The bench builds the block with NQ=4 and NSLOT=2. With these values, every queue is visited and the operation table fills after only two commands, so stalls on a full table, slot reuse and tag choice all come up within a short script. Expected command sequences are derived from the FIFO order in the requirements. They cover success requeueing, empty drops with and without a pending doorbell, discarding a disabled queue, and a command held under backpressure.

// File: rtl/txs_pkg.sv
package txs_pkg;
    typedef struct packed {
        logic en;
        logic act;
        logic pend;
    } qstate_t;

    typedef enum logic [1:0] {
        EV_CFG = 2'd0,
        EV_ST  = 2'd1,
        EV_DB  = 2'd2,
        EV_POP = 2'd3
    } ev_kind_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LOOK  = 2'd1,
        S_APPLY = 2'd2,
        S_CMD   = 2'd3
    } fsm_t;
endpackage

// File: rtl/txs_state_ram.sv
module txs_state_ram
    import txs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output qstate_t       rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  qstate_t       wr_data
);
    qstate_t       mem [DEPTH];
    logic [AW-1:0] addr_q;

    // two-stage read: address register, then data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rd_data <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (rd_req) addr_q <= rd_addr;
            rd_data <= mem[addr_q];
            if (wr_en) mem[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/txs_fifo.sv
module txs_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rp, wp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign dout  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push && !full) begin
                mem[wp] <= din;
                wp      <= inc(wp);
            end
            if (pop && !empty) rp <= inc(rp);
            cnt <= cnt + CW'(push && !full) - CW'(pop && !empty);
        end
    end
endmodule

// File: rtl/txs_op_table.sv
module txs_op_table #(
    parameter int NSLOT = 4,
    parameter int QW    = 4,
    localparam int TW   = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [QW-1:0] alloc_q,
    output logic [TW-1:0] free_tag,
    output logic          full,
    input  logic          rel,
    input  logic [TW-1:0] rel_tag,
    output logic [QW-1:0] rel_q
);
    logic [NSLOT-1:0] busy;
    logic [QW-1:0]    owner [NSLOT];

    always_comb begin
        free_tag = '0;
        for (int i = NSLOT - 1; i >= 0; i--)
            if (!busy[i]) free_tag = TW'(i);
    end

    assign full  = &busy;
    assign rel_q = owner[rel_tag];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
            for (int i = 0; i < NSLOT; i++) owner[i] <= '0;
        end else begin
            if (alloc) begin
                busy[free_tag]  <= 1'b1;
                owner[free_tag] <= alloc_q;
            end
            if (rel) busy[rel_tag] <= 1'b0;
        end
    end
endmodule

// File: rtl/txq_rr_sched.sv
module txq_rr_sched
    import txs_pkg::*;
#(
    parameter int NQ    = 16,
    parameter int NSLOT = 4,
    parameter int LEN_W = 16,
    localparam int QW   = $clog2(NQ),
    localparam int TW   = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    output logic             cfg_ready,
    input  logic [QW-1:0]    cfg_queue,
    input  logic             cfg_enable,
    input  logic             db_valid,
    output logic             db_ready,
    input  logic [QW-1:0]    db_queue,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [QW-1:0]    cmd_queue,
    output logic [TW-1:0]    cmd_tag,
    input  logic             st_valid,
    output logic             st_ready,
    input  logic [TW-1:0]    st_tag,
    input  logic [LEN_W-1:0] st_len
);
    fsm_t     state, nxt;
    ev_kind_t ev_kind, take_kind;
    logic [QW-1:0] ev_q, take_q;
    logic          ev_flag, take_flag, take_go;

    qstate_t ram_rdata, ram_wdata;
    logic    ram_we;

    logic          fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [QW-1:0] fifo_dout;

    logic          tbl_full, tbl_alloc, tbl_rel;
    logic [TW-1:0] tbl_free;
    logic [QW-1:0] tbl_rel_q;

    txs_state_ram #(.DEPTH(NQ)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .rd_req(take_go), .rd_addr(take_q), .rd_data(ram_rdata),
        .wr_en(ram_we), .wr_addr(ev_q), .wr_data(ram_wdata)
    );

    txs_fifo #(.DEPTH(NQ), .W(QW)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(fifo_push), .din(ev_q), .pop(fifo_pop),
        .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full)
    );

    txs_op_table #(.NSLOT(NSLOT), .QW(QW)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .alloc(tbl_alloc), .alloc_q(ev_q),
        .free_tag(tbl_free), .full(tbl_full),
        .rel(tbl_rel), .rel_tag(st_tag), .rel_q(tbl_rel_q)
    );

    assign cmd_queue = ev_q;
    assign cmd_tag   = tbl_free;
    assign tbl_alloc = cmd_valid && cmd_ready;
    assign tbl_rel   = st_valid && st_ready;

    // state register and captured event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            ev_kind <= EV_POP;
            ev_q    <= '0;
            ev_flag <= 1'b0;
        end else begin
            state <= nxt;
            if (take_go) begin
                ev_kind <= take_kind;
                ev_q    <= take_q;
                ev_flag <= take_flag;
            end
        end
    end

    // next state and outputs
    always_comb begin
        nxt       = state;
        cfg_ready = 1'b0;
        st_ready  = 1'b0;
        db_ready  = 1'b0;
        cmd_valid = 1'b0;
        fifo_pop  = 1'b0;
        fifo_push = 1'b0;
        ram_we    = 1'b0;
        ram_wdata = ram_rdata;
        take_go   = 1'b0;
        take_kind = EV_POP;
        take_q    = fifo_dout;
        take_flag = 1'b0;
        unique case (state)
            S_IDLE: begin
                cfg_ready = 1'b1;
                st_ready  = !cfg_valid;
                db_ready  = !cfg_valid && !st_valid;
                if (cfg_valid) begin
                    take_go = 1'b1; take_kind = EV_CFG;
                    take_q = cfg_queue; take_flag = cfg_enable;
                end else if (st_valid) begin
                    take_go = 1'b1; take_kind = EV_ST;
                    take_q = tbl_rel_q; take_flag = (st_len != '0);
                end else if (db_valid) begin
                    take_go = 1'b1; take_kind = EV_DB;
                    take_q = db_queue;
                end else if (!fifo_empty && !tbl_full) begin
                    take_go = 1'b1; fifo_pop = 1'b1;
                end
                if (take_go) nxt = S_LOOK;
            end
            S_LOOK: nxt = S_APPLY;
            S_APPLY: begin
                ram_we = 1'b1;
                nxt    = S_IDLE;
                unique case (ev_kind)
                    EV_CFG: ram_wdata.en = ev_flag;
                    EV_DB: begin
                        if (ram_rdata.en) begin
                            if (!ram_rdata.act) begin
                                ram_wdata.act = 1'b1;
                                fifo_push     = 1'b1;
                            end else begin
                                ram_wdata.pend = 1'b1;
                            end
                        end
                    end
                    EV_ST: begin
                        if (ev_flag || ram_rdata.pend) begin
                            fifo_push      = 1'b1;
                            ram_wdata.pend = 1'b0;
                        end else begin
                            ram_wdata.act = 1'b0;
                        end
                    end
                    EV_POP: begin
                        if (ram_rdata.en) begin
                            nxt = S_CMD;
                        end else begin
                            ram_wdata.act  = 1'b0;
                            ram_wdata.pend = 1'b0;
                        end
                    end
                endcase
            end
            S_CMD: begin
                cmd_valid = 1'b1;
                if (cmd_ready) nxt = S_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/txs_checker.sv
module txs_checker #(
    parameter int QW = 4,
    parameter int TW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [QW-1:0] cmd_queue,
    input logic [TW-1:0] cmd_tag,
    input logic          fifo_push,
    input logic          fifo_full,
    input logic          tbl_full,
    input logic          cfg_valid,
    input logic          cfg_ready,
    input logic          st_valid,
    input logic          st_ready,
    input logic          db_valid,
    input logic          db_ready
);
    assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_queue) && $stable(cmd_tag));

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    assert_slot_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !tbl_full);

    assert_one_input_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_valid && cfg_ready, st_valid && st_ready, db_valid && db_ready}));

    assert_no_input_in_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !cfg_ready && !st_ready && !db_ready);
endmodule

bind txq_rr_sched txs_checker #(.QW(QW), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_queue(cmd_queue), .cmd_tag(cmd_tag),
    .fifo_push(fifo_push), .fifo_full(fifo_full), .tbl_full(tbl_full),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .st_valid(st_valid), .st_ready(st_ready),
    .db_valid(db_valid), .db_ready(db_ready)
);

// File: tb/txq_rr_sched_tb.sv
module txq_rr_sched_tb;
    localparam int NQ = 4, NSLOT = 2, LEN_W = 16;
    localparam int QW = $clog2(NQ), TW = $clog2(NSLOT);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_valid = 0, cfg_enable = 0, db_valid = 0, st_valid = 0, cmd_ready = 1;
    logic [QW-1:0] cfg_queue = '0, db_queue = '0;
    logic [TW-1:0] st_tag = '0;
    logic [LEN_W-1:0] st_len = '0;
    logic cfg_ready, db_ready, st_ready, cmd_valid;
    logic [QW-1:0] cmd_queue;
    logic [TW-1:0] cmd_tag;

    int total = 0, bad = 0, log_n = 0;
    int log_q [32];
    int log_t [32];

    always #2.5 clk = ~clk;

    txq_rr_sched #(.NQ(NQ), .NSLOT(NSLOT), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_queue(cfg_queue), .cfg_enable(cfg_enable),
        .db_valid(db_valid), .db_ready(db_ready), .db_queue(db_queue),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_queue(cmd_queue), .cmd_tag(cmd_tag),
        .st_valid(st_valid), .st_ready(st_ready), .st_tag(st_tag), .st_len(st_len)
    );

    // command monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && cmd_valid && cmd_ready && log_n < 32) begin
            log_q[log_n] = int'(cmd_queue);
            log_t[log_n] = int'(cmd_tag);
            log_n = log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_cfg(input int q, input bit en);
        cfg_valid = 1; cfg_queue = QW'(q); cfg_enable = en;
        do @(negedge clk); while (!cfg_ready);
        @(posedge clk); #1 cfg_valid = 0;
    endtask

    task automatic do_db(input int q);
        db_valid = 1; db_queue = QW'(q);
        do @(negedge clk); while (!db_ready);
        @(posedge clk); #1 db_valid = 0;
    endtask

    task automatic do_st(input int t, input int len);
        st_valid = 1; st_tag = TW'(t); st_len = LEN_W'(len);
        do @(negedge clk); while (!st_ready);
        @(posedge clk); #1 st_valid = 0;
    endtask

    task automatic wait_cmds(input int n);
        for (int i = 0; i < 60 && log_n < n; i++) tick(1);
    endtask

    task automatic chk_cmd(input int idx, input int q, input int t, input string req);
        chk(log_n > idx, req, log_n, idx + 1);
        if (log_n > idx) begin
            chk(log_q[idx] == q, req, log_q[idx], q);
            chk(log_t[idx] == t, req, log_t[idx], t);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(4);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_valid == 0, "R1 cmd_valid", int'(cmd_valid), 0);
        chk(cfg_ready && db_ready && st_ready, "R1 readies", int'({cfg_ready, db_ready, st_ready}), 7);
        #1;
        // R3 doorbell to a disabled queue
        do_db(1);
        tick(20);
        chk(log_n == 0, "R3 disabled doorbell", log_n, 0);
        // R2 enable all queues, R4 FIFO order, R6 tags and full table
        for (int q = 0; q < NQ; q++) do_cfg(q, 1);
        for (int q = 0; q < NQ; q++) do_db(q);
        wait_cmds(2);
        tick(30);
        chk(log_n == 2, "R6 full table blocks", log_n, 2);
        chk_cmd(0, 0, 0, "R4/R2 first");
        chk_cmd(1, 1, 1, "R6 second tag");
        // R7 success requeues at tail
        do_st(0, 64);
        wait_cmds(3);
        chk_cmd(2, 2, 0, "R7 rr after success");
        do_st(1, 100);
        wait_cmds(4);
        chk_cmd(3, 3, 1, "R7 rr second");
        // R8 empty drops, empty with pending requeues
        do_st(0, 0);
        wait_cmds(5);
        chk_cmd(4, 0, 0, "R8 drop q2 then q0");
        do_db(3);
        do_st(1, 0);
        wait_cmds(6);
        chk_cmd(5, 1, 1, "R8 pending requeue");
        // R9 disabled queue discarded from FIFO
        do_cfg(3, 0);
        do_st(0, 0);
        tick(30);
        chk(log_n == 6, "R9 disabled discard", log_n, 6);
        do_st(1, 0);
        tick(30);
        chk(log_n == 6, "R8 empty drop idle", log_n, 6);
        do_db(2);
        wait_cmds(7);
        chk_cmd(6, 2, 0, "R4 reactivate q2");
        do_cfg(3, 1);
        do_db(3);
        wait_cmds(8);
        chk_cmd(7, 3, 1, "R9 discarded queue reactivates");
        // R10 backpressure
        cmd_ready = 0;
        do_st(0, 5);
        tick(10);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(cmd_valid == 1, "R10 valid held", int'(cmd_valid), 1);
            chk(cmd_queue == 2 && cmd_tag == 0, "R10 payload held", int'(cmd_queue), 2);
        end
        chk(log_n == 8, "R10 no accept", log_n, 8);
        @(posedge clk); #1 cmd_ready = 1;
        wait_cmds(9);
        chk_cmd(8, 2, 0, "R10 accepted");
        // R5 pending cleared by success, no duplicate
        do_db(3);
        do_st(1, 9);
        wait_cmds(10);
        chk_cmd(9, 3, 1, "R5 requeue once");
        do_st(1, 0);
        tick(40);
        chk(log_n == 10, "R5 no duplicate entry", log_n, 10);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule